// File: doc/BRIEF.md
# Oversampled UART Frame Receiver

This block turns a serial receive line into characters. A free-running tick at eight times the baud rate paces it. It finds the falling edge of a start bit and confirms it at mid-bit. It then samples each following bit at the centre of its eight-tick window. Before the line is used, it passes through a synchronizer. A loopback select can take the line from the local transmitter output instead of the external pin. Each character goes to a receive FIFO write port as a one-cycle push. The push carries the data, zero-extended to eight bits, and one error flag. That flag covers a bad parity bit, a low stop bit and a break, and does not say which of them occurred.

The frame format is set at run time by three inputs: word length, stop-bit count and parity mode. These are the same codes the companion transmitter uses. The block also drives a request-to-send output for hardware flow control. It takes the FIFO's free-entry count and withholds the request while the FIFO is close to full.

Top module: `uart_os_rx`

## Requirements
- R1: While reset is asserted, `push_valid` and `rts` are both low.
- R2: `len_code` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits arrive LSB first. `push_data` holds them in its low bits, and every unused upper bit is 0.
- R3: A start bit is accepted only if the line is still low four ticks after the falling edge is seen. A shorter low pulse produces no push.
- R4: `par_mode` 4 means odd parity and 6 means even parity. One parity bit follows the data bits. `push_err` is set when the total count of ones in the data and parity bit does not match the selected parity.
- R5: `par_mode` 5 (mark) requires the parity bit to be 1, and `par_mode` 7 (space) requires it to be 0. Any other value sets `push_err`.
- R6: `par_mode` values 0 to 3 mean no parity bit. The stop bit directly follows the data bits.
- R7: A low first stop bit sets `push_err`. After such a frame, no new start bit is accepted until the line has returned high.
- R8: A line held low for many frame times, which is a break, produces exactly one push, with data 0 and `push_err` set.
- R9: When `two_stop` is 1, the second stop bit is also sampled, and a low second stop bit sets `push_err`.
- R10: When `loop_en` is 1, characters are taken from `tx_loop_line` and `rxd_pin` is ignored.
- R11: While `afc_en` is 1, `rts` goes low one cycle after `fifo_free` is 2 or less, and goes high one cycle after it exceeds 2. While `afc_en` is 0, `rts` is high one cycle later.
- R12: Each character produces a push one clock cycle long. It lands one cycle after the tick on which the last stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_8x | input | 1 | One-cycle strobe at eight times the baud rate |
| rxd_pin | input | 1 | External serial input, idle high |
| tx_loop_line | input | 1 | Local transmitter output, used as the line in loopback |
| loop_en | input | 1 | 1 selects `tx_loop_line` as the source |
| len_code | input | 2 | Word length code: 5 plus the code gives the number of bits |
| two_stop | input | 1 | 1 selects two stop bits |
| par_mode | input | 3 | Parity mode: 0 to 3 none, 4 odd, 5 mark, 6 even, 7 space |
| afc_en | input | 1 | Enables automatic flow control of `rts` |
| fifo_free | input | 6 | Free entries in the receive FIFO |
| push_valid | output | 1 | One-cycle FIFO write strobe |
| push_data | output | 8 | Received character, zero-extended |
| push_err | output | 1 | Combined parity, framing and break error |
| rts | output | 1 | Request to send, high when the far end may transmit |

## Verification
The line crosses a two-stage synchronizer. The start bit is then seen on the next tick and confirmed four ticks later. Each later sample comes eight ticks after the one before, and the push registers one clock after the final stop sample. With a tick every four clocks, the push is due between 16 and 26 clocks after the last stop bit starts. The bench records the cycle of every push and checks that it falls inside a window of 12 to 28 clocks. It judges a character only after a full idle bit time has passed, and checks the absence of a push only after the frame would have ended. `rts` is registered, so the bench samples it two cycles after changing `fifo_free` or `afc_en`.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_HOLD
  } rx_state_t;

  // number of data bits for a word length code
  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // upper mode bit set means a parity bit is present
  function automatic logic parity_used(input logic [2:0] mode);
    return mode[2];
  endfunction

  // returns 1 when the received parity bit is wrong for the mode
  function automatic logic parity_bad(input logic [7:0] d, input logic pb,
                                      input logic [2:0] mode);
    logic bad;
    case (mode)
      3'd4:    bad = ~(^d ^ pb);  // odd
      3'd6:    bad = ^d ^ pb;     // even
      3'd5:    bad = ~pb;         // mark
      3'd7:    bad = pb;          // space
      default: bad = 1'b0;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/uart_os_rx_linesel.sv
module uart_os_rx_linesel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic loop_i,
  input  logic loop_en,
  output logic line_o
);
  logic raw;
  logic [SYNC_STAGES-1:0] sync_q;

  assign raw = loop_en ? loop_i : pin_i;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b1;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign line_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] len_code,
  input  logic       two_stop,
  input  logic [2:0] par_mode,
  output logic       push_valid,
  output logic [7:0] push_data,
  output logic       push_err,
  output logic       start_reject,
  output logic       bit_sample
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]      idx_q;
  logic [7:0]      data_q;
  logic            perr_q;
  logic            last_bit;

  assign last_bit     = (idx_q == 3'(word_bits(len_code) - 4'd1));
  assign start_reject = tick && (state_q == ST_START) && (cnt_q == MID) && line;
  assign bit_sample   = tick && (cnt_q == LAST) &&
                        (state_q inside {ST_DATA, ST_PAR, ST_STOP1, ST_STOP2});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      data_q     <= '0;
      perr_q     <= 1'b0;
      push_valid <= 1'b0;
      push_data  <= '0;
      push_err   <= 1'b0;
    end else begin
      push_valid <= 1'b0;
      if (state_q == ST_HOLD) begin
        if (line) state_q <= ST_IDLE;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        case (state_q)
          ST_IDLE: if (!line) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            perr_q  <= 1'b0;
          end
          ST_START: if (cnt_q == MID) begin
            cnt_q   <= '0;
            state_q <= line ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (cnt_q == LAST) begin
            data_q[idx_q] <= line;
            if (last_bit) state_q <= parity_used(par_mode) ? ST_PAR : ST_STOP1;
            else          idx_q   <= idx_q + 1'b1;
          end
          ST_PAR: if (cnt_q == LAST) begin
            perr_q  <= parity_bad(data_q, line, par_mode);
            state_q <= ST_STOP1;
          end
          ST_STOP1, ST_STOP2: if (cnt_q == LAST) begin
            if (state_q == ST_STOP1 && two_stop && line) begin
              state_q <= ST_STOP2;
            end else begin
              push_valid <= 1'b1;
              push_data  <= data_q;
              push_err   <= perr_q | ~line;
              state_q    <= line ? ST_IDLE : ST_HOLD;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_flow.sv
module uart_os_rx_flow #(
  parameter int FREE_W = 6,
  parameter int MARGIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              afc_en,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              rts
);
  localparam logic [FREE_W-1:0] LIMIT = FREE_W'(MARGIN);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rts <= 1'b0;
    else        rts <= afc_en ? (fifo_free > LIMIT) : 1'b1;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OSR         = 8,
  parameter int FREE_W      = 6,
  parameter int RTS_MARGIN  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_8x,
  input  logic              rxd_pin,
  input  logic              tx_loop_line,
  input  logic              loop_en,
  input  logic [1:0]        len_code,
  input  logic              two_stop,
  input  logic [2:0]        par_mode,
  input  logic              afc_en,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              push_err,
  output logic              rts
);
  logic rx_line;
  logic start_reject;
  logic bit_sample;

  uart_os_rx_linesel #(.SYNC_STAGES(SYNC_STAGES)) linesel_i (
    .clk(clk), .rst_n(rst_n), .pin_i(rxd_pin), .loop_i(tx_loop_line),
    .loop_en(loop_en), .line_o(rx_line)
  );

  uart_os_rx_frame #(.OSR(OSR)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_8x), .line(rx_line),
    .len_code(len_code), .two_stop(two_stop), .par_mode(par_mode),
    .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
    .start_reject(start_reject), .bit_sample(bit_sample)
  );

  uart_os_rx_flow #(.FREE_W(FREE_W), .MARGIN(RTS_MARGIN)) flow_i (
    .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .fifo_free(fifo_free), .rts(rts)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int FREE_W = 6,
  parameter int MARGIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_8x,
  input logic [1:0]        len_code,
  input logic              afc_en,
  input logic [FREE_W-1:0] fifo_free,
  input logic              push_valid,
  input logic [7:0]        push_data,
  input logic              start_reject,
  input logic              bit_sample,
  input logic              rts
);
  p_push_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_valid);

  p_push_after_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(tick_8x) && $past(bit_sample));

  p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && len_code == 2'd0) |-> push_data[7:5] == 3'b000);

  p_reject_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !push_valid);

  p_rts_near_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && fifo_free <= FREE_W'(MARGIN)) |=> !rts);

  p_rts_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && fifo_free > FREE_W'(MARGIN)) |=> rts);

  p_rts_noafc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_en |=> rts);
endmodule

bind uart_os_rx uart_os_rx_chk #(.FREE_W(FREE_W), .MARGIN(RTS_MARGIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_8x(tick_8x), .len_code(len_code),
  .afc_en(afc_en), .fifo_free(fifo_free), .push_valid(push_valid),
  .push_data(push_data), .start_reject(start_reject),
  .bit_sample(bit_sample), .rts(rts)
);

// File: tb/uart_os_rx_tb_top.sv
`timescale 1ns/1ps
module uart_os_rx_tb_top;
  localparam int BIT_CLK = 32;  // 8 ticks x 4 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_8x = 1'b0;
  logic rxd_pin = 1'b1;
  logic tx_loop_line = 1'b1;
  logic loop_en = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic two_stop = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic afc_en = 1'b0;
  logic [5:0] fifo_free = 6'd16;
  logic push_valid, push_err, rts;
  logic [7:0] push_data;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_push = 0, last_cyc = 0, dbl = 0, stop_cyc = 0;
  logic [7:0] last_data = 8'h00;
  logic last_err = 1'b0, prev_push = 1'b0, use_loop = 1'b0;
  logic [1:0] div = 2'd0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    div <= div + 2'd1;
    tick_8x <= (div == 2'd3);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (push_valid) begin
        n_push++;
        last_data = push_data;
        last_err = push_err;
        last_cyc = cyc;
        if (prev_push) dbl++;
      end
      prev_push = push_valid;
    end
  end

  uart_os_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick_8x(tick_8x), .rxd_pin(rxd_pin),
    .tx_loop_line(tx_loop_line), .loop_en(loop_en), .len_code(len_code),
    .two_stop(two_stop), .par_mode(par_mode), .afc_en(afc_en),
    .fifo_free(fifo_free), .push_valid(push_valid), .push_data(push_data),
    .push_err(push_err), .rts(rts)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int clocks);
    if (use_loop) tx_loop_line = v; else rxd_pin = v;
    repeat (clocks) @(negedge clk);
  endtask

  // full frame; flip inverts the correct parity bit
  task automatic send(input logic [7:0] d, input logic flip,
                      input logic s1, input logic s2);
    int nb = 5 + int'(len_code);
    logic [7:0] m = d & 8'((1 << nb) - 1);
    logic pb;
    case (par_mode)
      3'd4: pb = ~^m;
      3'd6: pb = ^m;
      3'd5: pb = 1'b1;
      default: pb = 1'b0;
    endcase
    drive(1'b0, BIT_CLK);
    for (int i = 0; i < nb; i++) drive(m[i], BIT_CLK);
    if (par_mode[2]) drive(pb ^ flip, BIT_CLK);
    stop_cyc = cyc;
    drive(s1, BIT_CLK);
    if (two_stop) begin
      stop_cyc = cyc;
      drive(s2, BIT_CLK);
    end
  endtask

  task automatic expect_char(input string tag, input int base,
                             input logic [7:0] ed, input logic ee);
    drive(1'b1, BIT_CLK);
    chk({tag, " count"}, n_push, base + 1);
    chk({tag, " data"}, last_data, ed);
    chk({tag, " err"}, last_err, ee);
    chk({tag, " timing"}, (last_cyc - stop_cyc >= 12 && last_cyc - stop_cyc <= 28), 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 push in reset", push_valid, 0);
    chk("R1 rts in reset", rts, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 rts no afc", rts, 1);
  endtask

  task automatic t_lengths;
    for (int l = 0; l < 4; l++) begin
      int base = n_push;
      len_code = 2'(l);
      send(8'hB6, 1'b0, 1'b1, 1'b1);
      expect_char("R2 length", base, 8'hB6 & 8'((1 << (5 + l)) - 1), 1'b0);
    end
    len_code = 2'd3;
  endtask

  task automatic t_glitch;
    int base = n_push;
    drive(1'b0, 8);
    drive(1'b1, 3 * BIT_CLK);
    chk("R3 glitch ignored", n_push, base);
  endtask

  task automatic t_parity;
    logic [2:0] modes [4] = '{3'd4, 3'd6, 3'd5, 3'd7};
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 2; f++) begin
        int base = n_push;
        par_mode = modes[k];
        send(8'h5B, f[0], 1'b1, 1'b1);
        expect_char(k < 2 ? "R4 odd/even" : "R5 mark/space", base, 8'h5B, f[0]);
      end
    end
    par_mode = 3'd0;
  endtask

  task automatic t_no_parity;
    int base = n_push;
    par_mode = 3'd2;
    send(8'hC3, 1'b0, 1'b1, 1'b1);
    expect_char("R6 code2 none", base, 8'hC3, 1'b0);
    par_mode = 3'd0;
  endtask

  task automatic t_framing;
    int base = n_push;
    send(8'h55, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 2 * BIT_CLK);
    expect_char("R7 framing", base, 8'h55, 1'b1);
    drive(1'b1, BIT_CLK);
    chk("R7 single push", n_push, base + 1);
    base = n_push;
    send(8'h3C, 1'b0, 1'b1, 1'b1);
    expect_char("R7 recover", base, 8'h3C, 1'b0);
  endtask

  task automatic t_break;
    int base = n_push;
    drive(1'b0, 20 * BIT_CLK);
    drive(1'b1, 2 * BIT_CLK);
    chk("R8 break count", n_push, base + 1);
    chk("R8 break data", last_data, 0);
    chk("R8 break err", last_err, 1);
  endtask

  task automatic t_two_stop;
    int base = n_push;
    two_stop = 1'b1;
    send(8'h81, 1'b0, 1'b1, 1'b1);
    expect_char("R9 two stop ok", base, 8'h81, 1'b0);
    base = n_push;
    send(8'h81, 1'b0, 1'b1, 1'b0);
    expect_char("R9 second stop low", base, 8'h81, 1'b1);
    drive(1'b1, BIT_CLK);
    two_stop = 1'b0;
  endtask

  task automatic t_loop;
    int base = n_push;
    loop_en = 1'b1;
    rxd_pin = 1'b0;
    use_loop = 1'b1;
    repeat (4) @(negedge clk);
    send(8'hE7, 1'b0, 1'b1, 1'b1);
    expect_char("R10 loopback", base, 8'hE7, 1'b0);
    use_loop = 1'b0;
    rxd_pin = 1'b1;
    loop_en = 1'b0;
    drive(1'b1, BIT_CLK);
  endtask

  task automatic t_rts;
    afc_en = 1'b1;
    fifo_free = 6'd5;
    repeat (2) @(negedge clk);
    chk("R11 rts room", rts, 1);
    fifo_free = 6'd2;
    repeat (2) @(negedge clk);
    chk("R11 rts at margin", rts, 0);
    fifo_free = 6'd0;
    repeat (2) @(negedge clk);
    chk("R11 rts full", rts, 0);
    fifo_free = 6'd3;
    repeat (2) @(negedge clk);
    chk("R11 rts reassert", rts, 1);
    fifo_free = 6'd1;
    afc_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 rts afc off", rts, 1);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_glitch();
    t_parity();
    t_no_parity();
    t_framing();
    t_break();
    t_two_stop();
    t_loop();
    t_rts();
    chk("R12 single-cycle push", dbl, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule